// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block collects the level-sensitive INTA# to INTD# requests of a few PCI device slots and folds them onto four shared interrupt lines. The fold depends on the slot number, so that devices in neighbouring slots spread their first pin across different lines. Each shared line then goes through a byte-wide steering register. That register either names one of sixteen legacy interrupt-controller inputs or parks the line, in which case it drives nothing. Each controller input is the OR of every shared line currently steered to it.

Software programs the four steering bytes through a dword-wide configuration write port with byte enables, and reads them back unchanged. A side query port reports, for any shared line, whether it is enabled and which input it drives. All pins are plain level and control signals. The block has no valid/ready handshake, because none of its traffic can be held back: a write is taken in the cycle it is presented, and a read or query is answered combinationally. The outputs come from a registered table of routed levels. That table is rebuilt in full every cycle from the live line levels and the current steering bytes, so a rewritten route can never leave an old output stuck high.

Top module: `pirq_router`

## Requirements
- R1: While reset is low and after it is released, every steering byte reads 0x80 and every output `irq_out` bit is 0, whatever the slot inputs are.
- R2: A steering byte value V below 16 makes its shared line drive `irq_out[V]`. Any value of 16 or more, such as 0x10 or 0xFF, disables the line, so it drives no output.
- R3: Each `irq_out` bit is high exactly when at least one enabled shared line steered to it is high. Two lines steered to the same input keep it high until both are low.
- R4: Slot input bit `i*4+x` is pin x (A=0 to D=3) of the slot numbered `FIRST_SLOT+i`. For a slot numbered s, it feeds shared line (x + s - 1) mod 4.
- R5: Pins of different slots that land on the same shared line are ORed before steering.
- R6: A write with `cfg_wr_addr` equal to 0x18 (byte offset 0x60) loads byte lane p (data bits 8p+7:8p) into the steering byte of line p, but only for lanes whose `cfg_wr_be[p]` is 1. Lanes with a 0 enable, and writes to any other address, change nothing.
- R7: A slot level change appears on `irq_out` after one rising edge. A steering write appears two edges after the write is presented. The new outputs are computed from the current levels, and contributions under the old route are dropped.
- R8: Reads with `cfg_rd_addr` equal to 0x18 return the four stored steering bytes, line p in bits 8p+7:8p, including the upper bits of a disable code. Reads at any other address return 0.
- R9: The query for line `qry_pirq` gives `qry_en`=1 and `qry_irq`=V when its steering byte V is below 16. Otherwise it gives `qry_en`=0 and `qry_irq`=0.
- R10: A reset asserted mid-run restores all steering bytes to 0x80 and clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | ADDR_W | Dword address of the write |
| cfg_wr_data | input | 32 | Write data, four byte lanes |
| cfg_wr_be | input | 4 | Byte-lane enables |
| cfg_rd_addr | input | ADDR_W | Dword address of the read |
| cfg_rd_data | output | 32 | Read data, combinational |
| slot_intx | input | NUM_SLOTS*4 | Device interrupt pins, active high |
| qry_pirq | input | 2 | Shared line being queried |
| qry_en | output | 1 | Queried line is enabled |
| qry_irq | output | 4 | Controller input of the queried line |
| irq_out | output | 16 | Interrupt-controller inputs |

## Verification
Every slot pin is raised on its own under a routing in which each line has a distinct target. This separates a wrong swizzle from a wrong steering decode. Overlapping patterns then put two pins on one line, and separately two lines on one target, and release them one at a time. That shows whether the merge and the OR hold an output until its last source drops. A line is rerouted while its input stays high, which exposes any contribution left stuck from the old route. The steering values 15, 16 and 0xFF, single-lane writes and writes to a neighbouring address probe the disable boundary and the lane masking.

// File: rtl/pirq_router_pkg.sv
package pirq_router_pkg;
  localparam int unsigned PIRQ_N   = 4;
  localparam int unsigned IRQ_N    = 16;
  localparam int unsigned ROUTE_W  = 8;
  localparam int unsigned IRQ_IDX_W = $clog2(IRQ_N);
  localparam int unsigned PIN_N    = 4;
  typedef logic [ROUTE_W-1:0] route_t;
  localparam route_t ROUTE_RESET = 8'h80;
endpackage

// File: rtl/pirq_swizzle.sv
module pirq_swizzle
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 4,
  parameter int unsigned FIRST_SLOT = 1
) (
  input  logic [NUM_SLOTS*PIN_N-1:0] intx_i,
  output logic [PIRQ_N-1:0]          pirq_o
);
  // Slot s pin x lands on line (x + s - 1) mod 4; +3 keeps it non-negative.
  always_comb begin
    pirq_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      for (int x = 0; x < PIN_N; x++) begin
        pirq_o[2'((x + FIRST_SLOT + i + 3) % PIRQ_N)] =
          pirq_o[2'((x + FIRST_SLOT + i + 3) % PIRQ_N)] | intx_i[i*PIN_N + x];
      end
    end
  end
endmodule

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_router_pkg::*;
#(
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned ROUTE_DWORD = 6'h18
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [31:0]                    wr_data,
  input  logic [3:0]                     wr_be,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [31:0]                    rd_data,
  input  logic [1:0]                     q_pirq,
  output logic                           q_en,
  output logic [IRQ_IDX_W-1:0]           q_irq,
  output logic [PIRQ_N-1:0][ROUTE_W-1:0] route_o
);
  logic hit;
  assign hit = wr_en && (wr_addr == ADDR_W'(ROUTE_DWORD));

  for (genvar p = 0; p < PIRQ_N; p++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               route_o[p] <= ROUTE_RESET;
      else if (hit && wr_be[p]) route_o[p] <= wr_data[p*8 +: 8];
    end

    // R6: a masked lane keeps its byte
    a_r6_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_be[p]) |=> $stable(route_o[p]));
  end

  assign rd_data = (rd_addr == ADDR_W'(ROUTE_DWORD)) ? route_o : 32'h0;

  route_t q_sel;
  assign q_sel = route_o[q_pirq];
  assign q_en  = (q_sel < route_t'(IRQ_N));
  assign q_irq = q_en ? q_sel[IRQ_IDX_W-1:0] : '0;

  // R1: the cycle after reset is released, all bytes hold the default
  a_r1_reset_default: assert property (@(posedge clk)
    ($past(!rst_n) && rst_n) |-> (route_o == {PIRQ_N{ROUTE_RESET}}));

  // R6: a write at a foreign address changes nothing
  a_r6_foreign_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != ADDR_W'(ROUTE_DWORD)) |=> $stable(route_o));
endmodule

// File: rtl/pirq_steer.sv
module pirq_steer
  import pirq_router_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [PIRQ_N-1:0]              lvl_i,
  input  logic [PIRQ_N-1:0][ROUTE_W-1:0] route_i,
  output logic [IRQ_N-1:0]               irq_o
);
  logic [IRQ_N-1:0][PIRQ_N-1:0] tbl_d, tbl_q;
  logic [PIRQ_N-1:0][IRQ_N-1:0] col;

  // Full rebuild each cycle: no entry survives a route or level change.
  always_comb begin
    for (int k = 0; k < IRQ_N; k++) begin
      for (int p = 0; p < PIRQ_N; p++) begin
        tbl_d[k][p] = lvl_i[p] && (route_i[p][ROUTE_W-1:IRQ_IDX_W] == '0) &&
                      (route_i[p][IRQ_IDX_W-1:0] == IRQ_IDX_W'(k));
        col[p][k]   = tbl_q[k][p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tbl_q <= '0;
    else        tbl_q <= tbl_d;
  end

  for (genvar k = 0; k < IRQ_N; k++) begin : g_or
    assign irq_o[k] = |tbl_q[k];
  end

  for (genvar p = 0; p < PIRQ_N; p++) begin : g_chk
    // R2: a disabled line owns no table entry one cycle later
    a_r2_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (route_i[p] >= ROUTE_W'(IRQ_N)) |=> (col[p] == '0));
    // R7: a low line leaves nothing behind under any route
    a_r7_no_stale: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl_i[p] |=> (col[p] == '0));
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
  import pirq_router_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 4,
  parameter int unsigned FIRST_SLOT  = 1,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned ROUTE_DWORD = 6'h18
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_wr_en,
  input  logic [ADDR_W-1:0]            cfg_wr_addr,
  input  logic [31:0]                  cfg_wr_data,
  input  logic [3:0]                   cfg_wr_be,
  input  logic [ADDR_W-1:0]            cfg_rd_addr,
  output logic [31:0]                  cfg_rd_data,
  input  logic [NUM_SLOTS*PIN_N-1:0]   slot_intx,
  input  logic [1:0]                   qry_pirq,
  output logic                         qry_en,
  output logic [IRQ_IDX_W-1:0]         qry_irq,
  output logic [IRQ_N-1:0]             irq_out
);
  logic [PIRQ_N-1:0]              pirq_lvl;
  logic [PIRQ_N-1:0][ROUTE_W-1:0] route;

  pirq_swizzle #(.NUM_SLOTS(NUM_SLOTS), .FIRST_SLOT(FIRST_SLOT)) u_swz (
    .intx_i (slot_intx),
    .pirq_o (pirq_lvl)
  );

  pirq_route_regs #(.ADDR_W(ADDR_W), .ROUTE_DWORD(ROUTE_DWORD)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr_en),
    .wr_addr (cfg_wr_addr),
    .wr_data (cfg_wr_data),
    .wr_be   (cfg_wr_be),
    .rd_addr (cfg_rd_addr),
    .rd_data (cfg_rd_data),
    .q_pirq  (qry_pirq),
    .q_en    (qry_en),
    .q_irq   (qry_irq),
    .route_o (route)
  );

  pirq_steer u_steer (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvl_i   (pirq_lvl),
    .route_i (route),
    .irq_o   (irq_out)
  );

  // R3: an active output needs an active shared line the cycle before
  a_r3_out_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out != '0) |-> $past(pirq_lvl != '0));

  // R1: outputs are quiet in the first cycle out of reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    ($past(!rst_n) && rst_n) |-> (irq_out == '0));
endmodule

// File: tb/tb_pirq_router.sv
module tb_pirq_router;
  localparam int NS = 4;
  logic clk = 0, rst_n = 0;
  logic cfg_wr_en = 0;
  logic [5:0] cfg_wr_addr = 0, cfg_rd_addr = 0;
  logic [31:0] cfg_wr_data = 0, cfg_rd_data;
  logic [3:0] cfg_wr_be = 0;
  logic [NS*4-1:0] slot_intx = 0;
  logic [1:0] qry_pirq = 0;
  logic qry_en;
  logic [3:0] qry_irq;
  logic [15:0] irq_out;

  always #4 clk = ~clk;

  pirq_router dut (.*);

  int n_vec = 0, n_bad = 0;
  logic [7:0] m_route [4];
  logic [15:0] sb_exp[$];
  string sb_tag[$];

  function automatic logic [15:0] model_out(input logic [NS*4-1:0] v);
    logic [3:0] lv = 0;
    logic [15:0] o = 0;
    for (int i = 0; i < NS; i++)
      for (int x = 0; x < 4; x++)
        if (v[i*4+x]) lv[(x + (i + 1) - 1) % 4] = 1'b1;
    for (int p = 0; p < 4; p++)
      if (lv[p] && m_route[p] < 8'd16) o[m_route[p][3:0]] = 1'b1;
    return o;
  endfunction

  // monitor: pop expectations and compare away from the active edge
  always @(negedge clk) begin
    if (sb_exp.size() > 0) begin
      logic [15:0] e;
      string t;
      e = sb_exp.pop_front();
      t = sb_tag.pop_front();
      n_vec++;
      if (irq_out !== e) begin
        n_bad++;
        $display("FAIL %s: irq_out=%h expected %h", t, irq_out, e);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int p = 0; p < 4; p++) m_route[p] = 8'h80;
  endtask

  task automatic expect_irq(input string tag);
    @(posedge clk); #1;
    sb_exp.push_back(model_out(slot_intx));
    sb_tag.push_back(tag);
    wait (sb_exp.size() == 0);
  endtask

  task automatic cfg_write(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_addr = a; cfg_wr_data = d; cfg_wr_be = be;
    @(negedge clk);
    cfg_wr_en = 0; cfg_wr_be = 0;
    if (a == 6'h18)
      for (int p = 0; p < 4; p++) if (be[p]) m_route[p] = d[p*8 +: 8];
  endtask

  task automatic set_intx(input logic [NS*4-1:0] v);
    @(negedge clk);
    slot_intx = v;
  endtask

  task automatic read_check(input string tag, input logic [5:0] a);
    @(negedge clk);
    cfg_rd_addr = a; #1;
    check(tag, cfg_rd_data,
          (a == 6'h18) ? {m_route[3], m_route[2], m_route[1], m_route[0]} : 32'h0);
  endtask

  task automatic query_check(input string tag, input logic [1:0] p);
    logic en;
    @(negedge clk);
    qry_pirq = p; #1;
    en = m_route[p] < 8'd16;
    check(tag, {27'h0, qry_en, qry_irq}, {27'h0, en, en ? m_route[p][3:0] : 4'h0});
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    slot_intx = '1;
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", {16'h0, irq_out}, 32'h0);
    rst_n = 1;
    read_check("R1 R8 default bytes", 6'h18);
    expect_irq("R1 R2 default disabled");

    // R2 R4: line 0 to input 5, slot 1 pin A
    set_intx(0);
    cfg_write(6'h18, 32'h0000_0005, 4'b0001);
    set_intx(16'h0001);
    expect_irq("R2 R4 line0 to 5");

    // R4: every pin alone, distinct targets per line
    cfg_write(6'h18, 32'h0B0A_0905, 4'hF);
    read_check("R8 full write readback", 6'h18);
    for (int b = 0; b < NS*4; b++) begin
      set_intx(16'(1) << b);
      expect_irq("R4 single pin swizzle");
    end

    // R5: slot1 pin B and slot2 pin A both land on line 1
    set_intx(16'h0012); expect_irq("R5 merged both");
    set_intx(16'h0010); expect_irq("R5 merged one left");
    set_intx(16'h0000); expect_irq("R5 merged none");

    // R3: lines 0 and 2 share input 7
    cfg_write(6'h18, 32'h0B07_0907, 4'hF);
    set_intx(16'h0005); expect_irq("R3 shared both");
    set_intx(16'h0004); expect_irq("R3 shared one left");
    set_intx(16'h0000); expect_irq("R3 shared none");

    // R6: lane masking and foreign address
    cfg_write(6'h18, 32'hFFFF_FFFF, 4'b0100);
    read_check("R6 single lane", 6'h18);
    set_intx(16'h000F);
    expect_irq("R6 R2 lane2 disabled by FF");
    cfg_write(6'h19, 32'h0000_0000, 4'hF);
    read_check("R6 foreign address ignored", 6'h18);
    read_check("R8 other address reads 0", 6'h19);
    expect_irq("R6 outputs after foreign write");

    // R7: reroute while input stays high
    set_intx(16'h0001);
    expect_irq("R7 before reroute");
    cfg_write(6'h18, 32'h0000_0003, 4'b0001);
    expect_irq("R7 old route dropped");
    query_check("R9 enabled query line0", 2'd0);
    query_check("R9 enabled query line1", 2'd1);

    // R2 R9 boundary values
    cfg_write(6'h18, 32'h0000_000F, 4'b0001);
    expect_irq("R2 value 15");
    cfg_write(6'h18, 32'h0000_0010, 4'b0001);
    expect_irq("R2 value 16 disables");
    query_check("R9 disabled query", 2'd0);
    query_check("R9 FF query", 2'd2);

    // R10: mid-run reset
    cfg_write(6'h18, 32'h0102_0304, 4'hF);
    set_intx(16'h00FF);
    expect_irq("R10 before reset");
    @(negedge clk); rst_n = 0; #1;
    model_reset();
    check("R10 outputs cleared", {16'h0, irq_out}, 32'h0);
    @(negedge clk); rst_n = 1;
    read_check("R10 bytes restored", 6'h18);
    expect_irq("R10 outputs after reset");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule